// File: doc/BRIEF.md
# Threshold-Pulse Signed Energy Accumulator

This block turns a stream of signed per-sample power words into a count of fixed-size energy quanta. On every sample strobe, which is nominally one every 125 µs (8 kHz), the power word is added into a wide signed residue. The residue's magnitude is compared against a programmable 48-bit threshold. When the positive threshold is reached, the energy register counts up by one and the threshold is removed from the residue. When the negative threshold is reached, the energy register counts down by one and the threshold is given back to the residue. The energy register therefore never sees the raw sum. It sees only quanta whose size is set by the threshold.

The energy register is signed and wraps in two's complement. A one-cycle pulse marks each wrap. A sticky flag records that the direction of energy flow has reversed, and writing 1 to a clear input removes it. A read request captures the energy value into a read-data register. When the read-with-reset enable is set, the same read also zeroes the counter, and a quantum that lands in that cycle is kept rather than lost.

Top module: `thr_energy_acc`

## Requirements
- R1: After a synchronous reset, `energy`, `rd_data`, `rd_valid`, `rev_flag` and `ovf_pulse` are all 0, and the residue is 0.
- R2: On a clock edge with `smp_stb` high, the residue gains `pwr_word`. If `thresh` is non-zero and the new residue is at least `thresh`, one quantum of +1 is produced and `thresh` is subtracted from the residue. The changed `energy` is visible after the second rising edge, counting the edge that sampled the strobe. At most one quantum is produced per strobe.
- R3: If the new residue is at most minus `thresh` (with `thresh` non-zero), one quantum of -1 is produced and `thresh` is added back to the residue, with the same timing as R2.
- R4: With `thresh` = 0x1FF6A6B and `pwr_word` equal to that full-scale value, every strobe adds exactly +1 to `energy`.
- R5: Without `smp_stb`, `pwr_word` is ignored: the residue and `energy` do not change.
- R6: `energy` is a signed two's-complement counter of ENERGY_W bits. Counting up from the largest positive value gives the most negative value, and counting down from the most negative value gives the largest positive value. `ovf_pulse` is high for exactly the one cycle in which the wrapped value first appears.
- R7: A cycle with `rd_req` high is followed by one cycle of `rd_valid` high, with `rd_data` holding the `energy` value from before that edge. If `rd_clr_en` was also high, `energy` is set to 0; otherwise `energy` is unchanged.
- R8: A quantum that reaches the energy register in the same edge as a clearing read is not lost: after that edge, `energy` equals that quantum (+1 or -1).
- R9: `rev_flag` rises when a quantum has the opposite sign to the previous quantum since reset. The first quantum never sets it. Once set, it stays high.
- R10: `rev_clr` high at an edge clears `rev_flag`. If a reversal is detected in that same edge, setting the flag takes precedence.
- R11: With `thresh` = 0, no quanta are produced and `energy` does not change, while the residue keeps summing the strobed power words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe (nominally 8 kHz) |
| pwr_word | input | PW (32) | Signed power for this sample |
| thresh | input | THR_W (48) | Unsigned quantum threshold; 0 disables quanta |
| rd_req | input | 1 | Read request for the energy register |
| rd_clr_en | input | 1 | When high, a read also zeroes the energy register |
| rev_clr | input | 1 | Write-1-to-clear for the reversal flag |
| energy | output | ENERGY_W (32) | Signed energy quantum count |
| rd_data | output | ENERGY_W (32) | Energy value captured by the last read |
| rd_valid | output | 1 | High for one cycle after a read |
| rev_flag | output | 1 | Sticky energy-direction reversal flag |
| ovf_pulse | output | 1 | One-cycle pulse when the energy count wraps |

## Verification
The quantizer is driven with four kinds of input. A small positive power that is not a divisor of the threshold tests the carrying of the remainder across quanta. A negative power after positive quanta tests the downward path and the reversal flag. A full-scale power equal to the threshold must yield one quantum per strobe. A zero threshold fed with large samples must yield nothing. The full-scale run is continued on a narrowed energy register until it wraps, which separates a correct two's-complement wrap and overflow pulse from saturation or a missing pulse. Reads with and without clearing are issued both on an idle pipeline and in the very edge a quantum lands, which separates a clear that keeps the quantum from one that drops it. Power changes without a strobe check that unstrobed cycles leave all state untouched.

// File: rtl/eacc_pkg.sv
package eacc_pkg;
  // Direction of the most recent energy quantum.
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_POS  = 2'd1,
    DIR_NEG  = 2'd2
  } qdir_t;
endpackage

// File: rtl/eacc_residue.sv
module eacc_residue #(
  parameter int PW    = 32,
  parameter int THR_W = 48,
  parameter int RW    = 50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [PW-1:0] pwr_word,
  input  logic [THR_W-1:0]     thresh,
  output logic                 q_pos,
  output logic                 q_neg
);
  logic signed [RW-1:0] res_q;
  logic signed [RW-1:0] sum_c;
  logic signed [RW-1:0] thr_c;
  logic signed [RW-1:0] nxt_c;
  logic                 thr_nz;
  logic                 up_c;
  logic                 dn_c;

  always_comb begin
    thr_nz = |thresh;
    thr_c  = $signed({{(RW-THR_W){1'b0}}, thresh});
    sum_c  = res_q + $signed({{(RW-PW){pwr_word[PW-1]}}, pwr_word});
    up_c   = thr_nz && (sum_c >= thr_c);
    dn_c   = thr_nz && !up_c && (sum_c <= -thr_c);
    if (up_c)      nxt_c = sum_c - thr_c;
    else if (dn_c) nxt_c = sum_c + thr_c;
    else           nxt_c = sum_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      q_pos <= 1'b0;
      q_neg <= 1'b0;
    end else begin
      q_pos <= smp_stb && up_c;
      q_neg <= smp_stb && dn_c;
      if (smp_stb) res_q <= nxt_c;
    end
  end

  // R5: an unstrobed cycle leaves the residue alone and emits nothing
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> (!q_pos && !q_neg && $stable(res_q)));

  // R11: a zero threshold never produces a quantum
  p_zero_thr_r11: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && thresh == '0) |=> (!q_pos && !q_neg));
endmodule

// File: rtl/eacc_energy.sv
module eacc_energy #(
  parameter int EW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 q_pos,
  input  logic                 q_neg,
  input  logic                 rd_req,
  input  logic                 rd_clr_en,
  output logic signed [EW-1:0] energy,
  output logic signed [EW-1:0] rd_data,
  output logic                 rd_valid,
  output logic                 ovf_pulse
);
  localparam logic signed [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

  logic signed [EW-1:0] base_c;
  logic signed [EW-1:0] delta_c;

  always_comb begin
    base_c = (rd_req && rd_clr_en) ? '0 : energy;
    if (q_pos)      delta_c = {{(EW-1){1'b0}}, 1'b1};
    else if (q_neg) delta_c = {EW{1'b1}};
    else            delta_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      energy    <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      energy    <= base_c + delta_c;
      rd_valid  <= rd_req;
      if (rd_req) rd_data <= energy;
      ovf_pulse <= (q_pos && base_c == MAXV) || (q_neg && base_c == MINV);
    end
  end

  // R6: an overflow pulse only accompanies a wrap between the extremes
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (($past(energy) == MAXV && energy == MINV) ||
                   ($past(energy) == MINV && energy == MAXV)));

  // R7: a read presents the pre-read value one cycle later
  p_snap_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (rd_valid && rd_data == $past(energy)));

  // R8: a clearing read keeps the quantum that lands with it
  p_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_clr_en && q_pos) |=> (energy == {{(EW-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/eacc_rev.sv
module eacc_rev
  import eacc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic q_pos,
  input  logic q_neg,
  input  logic rev_clr,
  output logic rev_flag
);
  qdir_t last_q;
  logic  flip_c;

  always_comb begin
    flip_c = (q_pos && last_q == DIR_NEG) || (q_neg && last_q == DIR_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= DIR_NONE;
      rev_flag <= 1'b0;
    end else begin
      if (q_pos)      last_q <= DIR_POS;
      else if (q_neg) last_q <= DIR_NEG;
      if (flip_c)       rev_flag <= 1'b1;
      else if (rev_clr) rev_flag <= 1'b0;
    end
  end

  // R9: the flag is sticky without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (rev_flag && !rev_clr) |=> rev_flag);

  // R10: a clear with no competing quantum drops the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rev_clr && !q_pos && !q_neg) |=> !rev_flag);
endmodule

// File: rtl/thr_energy_acc.sv
module thr_energy_acc #(
  parameter int PW       = 32,
  parameter int THR_W    = 48,
  parameter int ENERGY_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_stb,
  input  logic signed [PW-1:0]       pwr_word,
  input  logic [THR_W-1:0]           thresh,
  input  logic                       rd_req,
  input  logic                       rd_clr_en,
  input  logic                       rev_clr,
  output logic signed [ENERGY_W-1:0] energy,
  output logic signed [ENERGY_W-1:0] rd_data,
  output logic                       rd_valid,
  output logic                       rev_flag,
  output logic                       ovf_pulse
);
  localparam int RW = ((THR_W > PW) ? THR_W : PW) + 2;

  logic q_pos;
  logic q_neg;

  eacc_residue #(.PW(PW), .THR_W(THR_W), .RW(RW)) u_res (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .pwr_word (pwr_word),
    .thresh   (thresh),
    .q_pos    (q_pos),
    .q_neg    (q_neg)
  );

  eacc_energy #(.EW(ENERGY_W)) u_nrg (
    .clk       (clk),
    .rst       (rst),
    .q_pos     (q_pos),
    .q_neg     (q_neg),
    .rd_req    (rd_req),
    .rd_clr_en (rd_clr_en),
    .energy    (energy),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .ovf_pulse (ovf_pulse)
  );

  eacc_rev u_rev (
    .clk      (clk),
    .rst      (rst),
    .q_pos    (q_pos),
    .q_neg    (q_neg),
    .rev_clr  (rev_clr),
    .rev_flag (rev_flag)
  );

  // R2: one quantum per strobe, never both directions at once
  p_one_dir_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({q_pos, q_neg}));
endmodule

// File: tb/sim_thr_energy_acc.sv
`timescale 1ns/1ps
module sim_thr_energy_acc;
  localparam int PW = 32;
  localparam int THR_W = 48;
  localparam int EW = 8;
  localparam logic signed [EW-1:0] MAXE = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] MINE = {1'b1, {(EW-1){1'b0}}};

  typedef struct {
    logic signed [EW-1:0] e;
    logic                 rev;
    logic                 ovf;
    string                tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [PW-1:0] pwr_word = '0;
  logic [THR_W-1:0] thresh = '0;
  logic rd_req = 1'b0, rd_clr_en = 1'b0, rev_clr = 1'b0;
  logic signed [EW-1:0] energy, rd_data;
  logic rd_valid, rev_flag, ovf_pulse;

  int n_chk = 0;
  int n_fail = 0;
  item_t exp_q[$];
  logic d1 = 1'b0, d2 = 1'b0;

  longint mres = 0;
  longint mthr = 0;
  logic signed [EW-1:0] me = '0;
  int mlast = 0;
  logic mrev = 1'b0;

  always #2.5 clk = ~clk;

  thr_energy_acc #(.PW(PW), .THR_W(THR_W), .ENERGY_W(EW)) u0 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .pwr_word(pwr_word),
    .thresh(thresh), .rd_req(rd_req), .rd_clr_en(rd_clr_en),
    .rev_clr(rev_clr), .energy(energy), .rd_data(rd_data),
    .rd_valid(rd_valid), .rev_flag(rev_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic item_t apply(input int q, input string tag);
    item_t it;
    it.ovf = (q == 1 && me == MAXE) || (q == -1 && me == MINE);
    me = me + EW'(q);
    if (q != 0) begin
      if (mlast != 0 && mlast != q) mrev = 1'b1;
      mlast = q;
    end
    it.e = me; it.rev = mrev; it.tag = tag;
    return it;
  endfunction

  function automatic int quant(input longint p);
    longint s;
    s = mres + p;
    if (mthr != 0 && s >= mthr) begin mres = s - mthr; return 1; end
    if (mthr != 0 && s <= -mthr) begin mres = s + mthr; return -1; end
    mres = s;
    return 0;
  endfunction

  // Driver: one strobe, expected result pushed to the scoreboard
  task automatic sample(input longint p, input string tag);
    int q;
    @(negedge clk);
    smp_stb = 1'b1; pwr_word = PW'(p);
    q = quant(p);
    exp_q.push_back(apply(q, tag));
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic set_thr(input longint t);
    @(negedge clk);
    thresh = THR_W'(t); mthr = t;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input bit clr, input string tag);
    logic signed [EW-1:0] old;
    @(negedge clk);
    rd_req = 1'b1; rd_clr_en = clr; old = me;
    if (clr) me = '0;
    @(negedge clk);
    rd_req = 1'b0; rd_clr_en = 1'b0;
    chk(rd_valid == 1'b1, {tag, " rd_valid"}, rd_valid, 1);
    chk(rd_data == old, {tag, " rd_data"}, rd_data, old);
    chk(energy == me, {tag, " energy after read"}, energy, me);
  endtask

  // Monitor: compare each strobe's result two edges after it was sampled
  always @(posedge clk) begin
    d1 <= smp_stb;
    d2 <= d1;
  end

  always @(negedge clk) begin
    if (d2) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 scoreboard underrun", 0, 1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(energy == it.e, {it.tag, " energy"}, energy, it.e);
        chk(rev_flag == it.rev, {"R9 rev_flag (", it.tag, ")"}, rev_flag, it.rev);
        chk(ovf_pulse == it.ovf, {"R6 ovf_pulse (", it.tag, ")"}, ovf_pulse, it.ovf);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(energy == 0, "R1 energy", energy, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(rev_flag == 0, "R1 rev_flag", rev_flag, 0);
    chk(ovf_pulse == 0, "R1 ovf_pulse", ovf_pulse, 0);

    // R2 positive power, remainder carried across quanta
    set_thr(1000);
    for (int i = 0; i < 10; i++) sample(300, "R2");
    drain();
    chk(energy == 3, "R2 total", energy, 3);

    // R7 reads without and with clearing
    do_read(1'b0, "R7 keep");
    do_read(1'b1, "R7 clear");

    // R3 negative power, R9 reversal
    for (int i = 0; i < 5; i++) sample(-450, "R3");
    drain();
    chk(energy == -2, "R3 total", energy, -2);
    chk(rev_flag == 1, "R9 set after reversal", rev_flag, 1);
    sample(-450, "R9 sticky");
    drain();
    chk(rev_flag == 1, "R9 sticky", rev_flag, 1);

    // R10 clear
    @(negedge clk); rev_clr = 1'b1; mrev = 1'b0;
    @(negedge clk); rev_clr = 1'b0;
    chk(rev_flag == 0, "R10 cleared", rev_flag, 0);

    // Mixed alternating pattern
    for (int i = 0; i < 8; i++) sample((i % 2 == 0) ? 700 : -200, "R2 mixed");
    drain();

    // R5 power without strobe is ignored
    begin
      logic signed [EW-1:0] hold;
      hold = energy;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); pwr_word = 32'sh4000_0000;
      end
      @(negedge clk);
      chk(energy == hold, "R5 energy unchanged", energy, hold);
      chk(energy == me, "R5 model match", energy, me);
    end
    sample(100, "R5 residue intact");
    drain();

    // R4 full scale, continued into R6 wrap
    set_thr(64'h1FF6A6B);
    for (int i = 0; i < 260; i++) sample(64'h1FF6A6B, "R4");
    drain();

    // R8 clearing read coinciding with a quantum
    begin
      logic signed [EW-1:0] old;
      int q;
      @(negedge clk);
      smp_stb = 1'b1; pwr_word = 32'h1FF6A6B;
      q = quant(64'h1FF6A6B);
      @(negedge clk);
      smp_stb = 1'b0; rd_req = 1'b1; rd_clr_en = 1'b1;
      old = me; me = '0;
      exp_q.push_back(apply(q, "R8"));
      @(negedge clk);
      rd_req = 1'b0; rd_clr_en = 1'b0;
      chk(rd_data == old, "R8 rd_data", rd_data, old);
      chk(energy == 1, "R8 quantum kept", energy, 1);
    end
    drain();

    // R11 zero threshold
    set_thr(0);
    for (int i = 0; i < 4; i++) sample(500000, "R11");
    drain();
    chk(energy == me, "R11 energy unchanged", energy, me);

    drain();
    chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule